// File: doc/BRIEF.md
# Doorbell Interrupt Unit

This block holds, for each of four processors, a 32-bit doorbell pending register and a 32-bit doorbell enable register. Any agent can raise a doorbell by writing one trigger word. The word names a doorbell number and a set of destination processors, and the block sets that doorbell's pending bit in each named processor. The trigger can arrive on the register bus at the shared trigger offset. It can also arrive on a separate inbound trigger port, which carries message-signalled interrupt writes from the host bridge.

Doorbells 0 to 7 are inter-processor interrupts and doorbells 16 to 31 are message-signalled interrupts. Bits 8 to 15 are reserved. For each processor the block drives two level outputs, one for each group. Each output is the OR of the pending bits in that group that are also enabled. These outputs feed an interrupt distributor as its sources 0 and 1.

Software acknowledges doorbells by writing the complement of the bits it has handled to its pending register. A zero clears a bit and a one leaves it unchanged. A trigger that lands in the same cycle as such a write still sets its bit.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every pending and enable register reads zero and all `ipi_irq` and `msi_irq` outputs are low.
- R2: A bus write to offset 0x04 uses data bits [4:0] as doorbell number D and bits [11:8] as the destination map, where bit 8+c selects processor c. It sets pending bit D in every selected processor and leaves all other processors unchanged.
- R3: An `ext_trig_valid` cycle decodes `ext_trig_word` with the same encoding as R2. A bus trigger and an inbound trigger in the same cycle both take effect.
- R4: A bus write to offset 0x08 acts on the pending register of the processor named by `req_cpu`. Each data bit that is 0 clears the matching pending bit and each bit that is 1 leaves it unchanged.
- R5: When a trigger sets a bit in the same cycle as an R4 write to that processor, the bit ends up set, even if the write carries a 0 for it.
- R6: A bus write to offset 0x0C loads all 32 data bits into the enable register of the processor named by `req_cpu`, and a read at 0x0C returns that register.
- R7: Pending bits 8 to 15 always read as zero, and a trigger whose D is in 8..15 changes no pending register.
- R8: `ipi_irq[c]` is high exactly when some bit in 0..7 is both pending and enabled for processor c.
- R9: `msi_irq[c]` is high exactly when some bit in 16..31 is both pending and enabled for processor c. The message value 0xF00 | (n+16) sets bit n+16 in all four processors.
- R10: A read (`req_valid` with `req_write` low) raises `rd_valid` for one cycle on the next clock. `rd_data` then carries the addressed register as it stood before that edge. Reads at 0x04 or at any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 2 | Processor whose private registers are accessed |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| ext_trig_valid | input | 1 | Inbound trigger word present |
| ext_trig_word | input | 32 | Inbound trigger word (R2 encoding) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ipi_irq | output | 4 | Per-processor IPI summary |
| msi_irq | output | 4 | Per-processor MSI summary |

## Verification
The hardest case is a trigger that collides with an acknowledge write to the same processor. The bus can carry only one access per cycle, so the bench drives a pending-register write on the bus and, in the same cycle, an inbound trigger for a bit that the write clears. It then reads the register back and expects the bit to be set. A companion cycle issues a bus trigger and an inbound trigger together for different processors, and both bits must land. The scoreboard holds an independent model of all eight registers, and every read and every summary output is compared against that model.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    localparam int OFS_TRIGGER = 'h04;
    localparam int OFS_PENDING = 'h08;
    localparam int OFS_ENABLE  = 'h0C;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_TRIGGER,
        ACC_PENDING,
        ACC_ENABLE
    } access_e;

endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode #(
    parameter int NUM_CPUS = 4,
    parameter int DATA_W   = 32,
    parameter int IPI_BITS = 8,
    parameter int MSI_LO   = 16,
    parameter int MAP_LSB  = 8
) (
    input  logic                             valid_i,
    input  logic [DATA_W-1:0]                word_i,
    output logic [NUM_CPUS-1:0][DATA_W-1:0]  set_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] LIVE_MASK =
        ({DATA_W{1'b1}} << MSI_LO) | ((DATA_W'(1) << IPI_BITS) - DATA_W'(1));

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] onehot;

    always_comb begin
        idx    = word_i[IDX_W-1:0];
        onehot = (DATA_W'(1) << idx) & LIVE_MASK;
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_dest
        always_comb begin
            set_o[c] = (valid_i && word_i[MAP_LSB+c]) ? onehot : '0;
        end
    end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank #(
    parameter int DATA_W   = 32,
    parameter int IPI_BITS = 8,
    parameter int MSI_LO   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic              pend_we_i,
    input  logic              en_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] pend_o,
    output logic [DATA_W-1:0] en_o,
    output logic              ipi_o,
    output logic              msi_o
);
    localparam logic [DATA_W-1:0] LIVE_MASK =
        ({DATA_W{1'b1}} << MSI_LO) | ((DATA_W'(1) << IPI_BITS) - DATA_W'(1));

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pend_we_i) begin
            st_d.pend = st_q.pend & wdata_i;
        end
        st_d.pend = (st_d.pend | set_i) & LIVE_MASK;
        if (en_we_i) begin
            st_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign ipi_o  = |(st_q.pend[IPI_BITS-1:0] & st_q.en[IPI_BITS-1:0]);
    assign msi_o  = |(st_q.pend[DATA_W-1:MSI_LO] & st_q.en[DATA_W-1:MSI_LO]);

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & LIVE_MASK) != '0) |=>
            ((pend_o & $past(set_i & LIVE_MASK)) == $past(set_i & LIVE_MASK)));

    // R5
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_we_i && (set_i & LIVE_MASK) != '0) |=>
            ((pend_o & $past(set_i & LIVE_MASK)) == $past(set_i & LIVE_MASK)));

    // R4
    zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_we_i && set_i == '0) |=> ((pend_o & ~$past(wdata_i)) == '0));

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[MSI_LO-1:IPI_BITS] == '0);

    // R6
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_o == $past(wdata_i)));

    // R8
    ipi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o[IPI_BITS-1:0] == '0) |-> !ipi_o);

    // R9
    msi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[DATA_W-1:MSI_LO] == '0) |-> !msi_o);
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit #(
    parameter int NUM_CPUS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int IPI_BITS = 8,
    parameter int MSI_LO   = 16,
    parameter int MAP_LSB  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [$clog2(NUM_CPUS)-1:0] req_cpu,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic                        ext_trig_valid,
    input  logic [DATA_W-1:0]           ext_trig_word,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_CPUS-1:0]         ipi_irq,
    output logic [NUM_CPUS-1:0]         msi_irq
);
    import doorbell_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rsp_t;

    access_e                          acc;
    logic                             bus_trig;
    logic [NUM_CPUS-1:0][DATA_W-1:0]  set_bus, set_ext;
    logic [NUM_CPUS-1:0][DATA_W-1:0]  pend_all, en_all;
    rsp_t                             rsp_d, rsp_q;

    always_comb begin
        acc = ACC_NONE;
        if (req_valid) begin
            if (req_addr == ADDR_W'(OFS_TRIGGER))      acc = ACC_TRIGGER;
            else if (req_addr == ADDR_W'(OFS_PENDING)) acc = ACC_PENDING;
            else if (req_addr == ADDR_W'(OFS_ENABLE))  acc = ACC_ENABLE;
        end
        bus_trig = req_write && (acc == ACC_TRIGGER);
    end

    db_trig_decode #(
        .NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W), .IPI_BITS(IPI_BITS),
        .MSI_LO(MSI_LO), .MAP_LSB(MAP_LSB)
    ) u_dec_bus (
        .valid_i(bus_trig), .word_i(req_wdata), .set_o(set_bus)
    );

    db_trig_decode #(
        .NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W), .IPI_BITS(IPI_BITS),
        .MSI_LO(MSI_LO), .MAP_LSB(MAP_LSB)
    ) u_dec_ext (
        .valid_i(ext_trig_valid), .word_i(ext_trig_word), .set_o(set_ext)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        logic pend_we, en_we;
        always_comb begin
            pend_we = req_write && (acc == ACC_PENDING) && (req_cpu == c);
            en_we   = req_write && (acc == ACC_ENABLE)  && (req_cpu == c);
        end
        db_cpu_bank #(
            .DATA_W(DATA_W), .IPI_BITS(IPI_BITS), .MSI_LO(MSI_LO)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_i(set_bus[c] | set_ext[c]),
            .pend_we_i(pend_we), .en_we_i(en_we), .wdata_i(req_wdata),
            .pend_o(pend_all[c]), .en_o(en_all[c]),
            .ipi_o(ipi_irq[c]), .msi_o(msi_irq[c])
        );
    end

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = req_valid && !req_write;
        if (!req_write) begin
            case (acc)
                ACC_PENDING: rsp_d.data = pend_all[req_cpu];
                ACC_ENABLE:  rsp_d.data = en_all[req_cpu];
                default:     rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid = rsp_q.vld;
    assign rd_data  = rsp_q.data;

    // R10
    read_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R10
    trigger_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(OFS_TRIGGER)) |=> (rd_data == '0));
endmodule

// File: tb/doorbell_unit_test.sv
`timescale 1ns/1ps
module doorbell_unit_test;
    localparam logic [31:0] LIVE = 32'hFFFF_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_cpu = '0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        ext_trig_valid = 1'b0;
    logic [31:0] ext_trig_word = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  ipi_irq, msi_irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] m_pend [4];
    logic [31:0] m_en   [4];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    doorbell_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_cpu(req_cpu),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ext_trig_valid(ext_trig_valid), .ext_trig_word(ext_trig_word),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ipi_irq(ipi_irq), .msi_irq(msi_irq)
    );

    function automatic void model_trig(input logic [31:0] w);
        logic [31:0] b;
        b = (32'd1 << w[4:0]) & LIVE;
        for (int c = 0; c < 4; c++) if (w[8+c]) m_pend[c] |= b;
    endfunction

    task automatic finish_op();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; ext_trig_valid = 1'b0;
    endtask

    task automatic bus_wr(input logic [1:0] cpu, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cpu = cpu; req_addr = a; req_wdata = d;
        if (a == 8'h04) model_trig(d);
        else if (a == 8'h08) m_pend[cpu] &= d & LIVE;
        else if (a == 8'h0C) m_en[cpu] = d;
        finish_op();
    endtask

    task automatic bus_rd(input logic [1:0] cpu, input logic [7:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = cpu; req_addr = a;
        if (a == 8'h08)      exp_q.push_back(m_pend[cpu]);
        else if (a == 8'h0C) exp_q.push_back(m_en[cpu]);
        else                 exp_q.push_back(32'h0);
        tag_q.push_back(tag);
        finish_op();
    endtask

    task automatic ext_trig(input logic [31:0] w);
        @(negedge clk);
        ext_trig_valid = 1'b1; ext_trig_word = w;
        model_trig(w);
        finish_op();
    endtask

    // One cycle carrying a bus write and an inbound trigger together
    task automatic bus_and_ext(input logic [1:0] cpu, input logic [7:0] a,
                               input logic [31:0] d, input logic [31:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cpu = cpu; req_addr = a; req_wdata = d;
        ext_trig_valid = 1'b1; ext_trig_word = w;
        if (a == 8'h04) model_trig(d);
        else if (a == 8'h08) m_pend[cpu] &= d & LIVE;
        model_trig(w);
        finish_op();
    endtask

    task automatic chk_irq(input string tag);
        logic [3:0] ei, em;
        for (int c = 0; c < 4; c++) begin
            ei[c] = |(m_pend[c][7:0] & m_en[c][7:0]);
            em[c] = |(m_pend[c][31:16] & m_en[c][31:16]);
        end
        n_vec++;
        if (ipi_irq !== ei || msi_irq !== em) begin
            n_bad++;
            $display("FAIL %s: ipi=%b msi=%b expected ipi=%b msi=%b", tag, ipi_irq, msi_irq, ei, em);
        end
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10: unexpected response %h expected none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s: read %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic read_all(input string tag);
        for (int c = 0; c < 4; c++) bus_rd(2'(c), 8'h08, tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_pend[c] = '0; m_en[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_all("R1 pending");
        for (int c = 0; c < 4; c++) bus_rd(2'(c), 8'h0C, "R1 enable");
        chk_irq("R1 outputs");

        // R2 bus trigger D=3 to cpus 0 and 2
        bus_wr(0, 8'h04, 32'h0000_0503);
        read_all("R2 trigger");
        chk_irq("R8 masked");

        // R6 enable write and read back, R8 summary
        bus_wr(0, 8'h0C, 32'hFFFF_00FF);
        bus_rd(0, 8'h0C, "R6 enable");
        chk_irq("R8 ipi");

        // R9 message value for vector 5 reaches all cpus
        ext_trig(32'h0000_0F00 | 32'd21);
        bus_wr(1, 8'h0C, 32'hFFFF_0000);
        read_all("R9 msi");
        chk_irq("R9 msi summary");

        // R4 acknowledge bit 3 on cpu0 only
        bus_wr(0, 8'h08, ~32'h0000_0008);
        read_all("R4 clear");
        chk_irq("R4 ipi drop");

        // R7 reserved doorbell numbers
        bus_wr(0, 8'h04, 32'h0000_0F0A);
        ext_trig(32'h0000_0F0F);
        read_all("R7 reserved");

        // R5 trigger collides with a clear-all on cpu2
        bus_and_ext(2, 8'h08, 32'h0, 32'h0000_0403);
        bus_rd(2, 8'h08, "R5 collision");
        bus_wr(2, 8'h0C, 32'h0000_0008);
        chk_irq("R5 ipi");

        // R3 bus and inbound triggers together
        bus_and_ext(0, 8'h04, 32'h0000_0207, 32'h0000_081F);
        read_all("R3 dual");
        bus_wr(3, 8'h0C, 32'h8000_0000);
        chk_irq("R3 summary");

        // Edge numbers D=16 and D=31 on cpu1
        ext_trig(32'h0000_0210);
        bus_wr(1, 8'h04, 32'h0000_021F);
        bus_rd(1, 8'h08, "R2 edges");

        // R10 unmapped and trigger offset reads
        bus_rd(1, 8'h04, "R10 trigger offset");
        bus_rd(1, 8'h10, "R10 unmapped");

        // Clear everything with acks, summaries fall
        for (int c = 0; c < 4; c++) bus_wr(2'(c), 8'h08, 32'h0);
        read_all("R4 full clear");
        chk_irq("R8 R9 idle");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL R10: %0d reads unanswered expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule